// File: doc/BRIEF.md
# Half-Bridge Mode Manager

This block sets the overall operating mode of a half-bridge gate driver. Each clock it samples four synchronous inputs: a supply-undervoltage flag, an enable, a three-way classification of the PWM input (low, high, or inside the mid-level window) and a switch-node overvoltage comparator. From these it produces a 2-bit mode code for the gate sequencer that follows it. The modes are normal drive (the sequencer follows PWM), all switches off, or low side held on for protection.

A PWM input that stays inside the mid-level window for a set number of cycles puts the block into a high-impedance state with both switches off. The block also starts in that state after reset. A valid PWM edge brings the block back to normal drive. Startup overvoltage protection is armed only when the supply leaves undervoltage while the block is high-impedance. Once armed, an overvoltage reading latches the low side on. That latch, and the armed state, are cleared by the first PWM edge to a valid level, and protection then stays off until the next undervoltage episode. The mode output is registered, so it follows the inputs one clock later.

Top module: `dhz_mode_mgr`

## Requirements
- R1: While `uv_i` is 1, the mode one cycle later is off (00). Undervoltage also forces the high-impedance state, clears the hold-off count, clears the armed state and clears the low-side latch.
- R2: With `uv_i` 0 and `en_i` 0, the mode one cycle later is off (00), whatever PWM does.
- R3: With `en_i` 1, the block enters high-impedance (mode 00) at the clock edge that samples the HOLD_CYC-th consecutive window code on `pwm_lvl_i` (1x). A shorter stretch, or enable going low, restarts the count.
- R4: High-impedance is left at the edge that samples a PWM transition. A transition is a valid code (00 low, 01 high) that differs from the code sampled one cycle earlier. The first sample after reset is never a transition, so a steady valid level leaves the block high-impedance.
- R5: After reset the block is high-impedance, protection is unarmed, and the mode is off.
- R6: Protection arms at the first edge that samples `uv_i` 0 after reset or after undervoltage. While armed, an edge that samples `ovp_i` 1 latches the low side on: mode 10 when `en_i` is 1.
- R7: A PWM transition clears both the latch and the armed state. Later high-impedance entries and `ovp_i` pulses then have no effect until a new undervoltage-clear event.
- R8: The mode code is only ever 00 (off), 01 (normal) or 10 (low side on). It is never 11.
- R9: `en_i` 0 forces the mode to off but keeps an active latch. When enable returns to 1, the mode is 10 again.
- R10: With `uv_i` 0, `en_i` 1, the block not high-impedance and no latch, the mode is normal (01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_i | input | 1 | Supply below undervoltage threshold |
| en_i | input | 1 | Driver enable |
| pwm_lvl_i | input | 2 | PWM class: 00 low, 01 high, 1x mid-level window |
| ovp_i | input | 1 | Switch node above pre-overvoltage threshold |
| mode_o | output | 2 | 00 off, 01 normal, 10 low side on |

## Verification
The assertions assume that every input is already synchronous and settled at the clock edge. They also assume that the reset lasts at least one edge, and that the window code may arrive as either 10 or 11. The stimulus drives inputs only on the falling clock edge. It uses both window codes, and it covers undervoltage with enable and PWM in every state. Window stretches are one cycle shorter than the hold-off and also longer than it, so the assertions are tested at the expiry boundary as well as in steady states.

// File: rtl/dhz_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the half-bridge mode manager.
// Assumes: PWM class codes arrive already synchronised.
package dhz_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_RUN  = 2'b01,
        MODE_LSON = 2'b10
    } drv_mode_e;

    localparam logic [1:0] PWM_LO = 2'b00;
    localparam logic [1:0] PWM_HI = 2'b01;
endpackage

// File: rtl/dhz_pwm_edge.sv
`timescale 1ns/1ps
// Classifies the PWM code and flags transitions to a valid level.
// Assumes: bit 1 set means mid-level window; the first sample after reset
// is never treated as a transition.
module dhz_pwm_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwm_lvl_i,
    output logic       in_win_o,
    output logic       trans_o
);
    logic [1:0] prev_q;
    logic       seen_q;

    // Remember last sampled code and that at least one sample exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 2'b10;
            seen_q <= 1'b0;
        end else begin
            prev_q <= pwm_lvl_i;
            seen_q <= 1'b1;
        end
    end

    // Window membership and valid-level change detection.
    always_comb begin
        in_win_o = pwm_lvl_i[1];
        trans_o  = seen_q && !pwm_lvl_i[1] && (pwm_lvl_i != prev_q);
    end
endmodule

// File: rtl/dhz_holdoff.sv
`timescale 1ns/1ps
// Counts consecutive qualifying window cycles; pulses expire_o on the
// HOLD_CYC-th one. Assumes run_i already folds in enable and state.
module dhz_holdoff #(
    parameter int HOLD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Expiry when the current qualifying cycle is the last one needed.
    always_comb expire_o = run_i && (cnt_q == LAST);

    // Advance while qualifying, restart otherwise or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || expire_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/dhz_ovp_guard.sv
`timescale 1ns/1ps
// Startup overvoltage guard: arms when undervoltage clears, latches the
// low side on an overvoltage while armed, clears on clr_i.
// Assumes: reset is treated as an undervoltage episode.
module dhz_ovp_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_i,
    input  logic ovp_i,
    input  logic clr_i,
    output logic uv_q_o,
    output logic armed_o,
    output logic latch_o
);
    logic uv_q;
    logic armed_q;
    logic latch_q;
    logic arm_evt;

    // Undervoltage-clear event.
    always_comb arm_evt = uv_q && !uv_i;

    // Track the supply flag from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) uv_q <= 1'b1;
        else        uv_q <= uv_i;
    end

    // Armed flag: set on supply-good edge, dropped on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed_q <= 1'b0;
        else if (clr_i)   armed_q <= 1'b0;
        else if (arm_evt) armed_q <= 1'b1;
    end

    // Low-side latch: set on overvoltage while armed, held until clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                latch_q <= 1'b0;
        else if (clr_i)            latch_q <= 1'b0;
        else if (armed_q && ovp_i) latch_q <= 1'b1;
    end

    always_comb begin
        uv_q_o  = uv_q;
        armed_o = armed_q;
        latch_o = latch_q;
    end

    p_latch_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ovp_i && !clr_i) |=> latch_q);
    p_latch_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i) |=> latch_q);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!latch_q && !armed_q));
endmodule

// File: rtl/dhz_mode_mgr.sv
`timescale 1ns/1ps
// Top: resolves undervoltage, enable, high-impedance and protection latch
// into one registered-state mode code for the gate sequencer.
// Assumes: all inputs synchronous to clk; mode follows inputs by one cycle.
module dhz_mode_mgr
    import dhz_pkg::*;
#(
    parameter int HOLD_CYC = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_i,
    input  logic       en_i,
    input  logic [1:0] pwm_lvl_i,
    input  logic       ovp_i,
    output logic [1:0] mode_o
);
    logic      in_win;
    logic      trans;
    logic      expire;
    logic      hold_run;
    logic      clr;
    logic      uv_q;
    logic      armed;
    logic      latch;
    logic      hiz_q;
    logic      en_q;
    drv_mode_e mode_w;

    dhz_pwm_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_lvl_i (pwm_lvl_i),
        .in_win_o  (in_win),
        .trans_o   (trans)
    );

    // Hold-off qualifies only while enabled, supplied and not yet off.
    always_comb hold_run = en_i && !uv_i && in_win && !hiz_q;

    dhz_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (hold_run),
        .expire_o (expire)
    );

    // Protection clears on undervoltage or on a valid PWM transition.
    always_comb clr = uv_i || trans;

    dhz_ovp_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_i    (uv_i),
        .ovp_i   (ovp_i),
        .clr_i   (clr),
        .uv_q_o  (uv_q),
        .armed_o (armed),
        .latch_o (latch)
    );

    // High-impedance state: forced by undervoltage, left on transition.
    always_ff @(posedge clk) begin
        if (!rst_n)      hiz_q <= 1'b1;
        else if (uv_i)   hiz_q <= 1'b1;
        else if (trans)  hiz_q <= 1'b0;
        else if (expire) hiz_q <= 1'b1;
    end

    // Registered enable so mode reflects one consistent sample.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    // Mode priority: supply, enable, protection latch, high-impedance.
    always_comb begin
        if (uv_q)       mode_w = MODE_OFF;
        else if (!en_q) mode_w = MODE_OFF;
        else if (latch) mode_w = MODE_LSON;
        else if (hiz_q) mode_w = MODE_OFF;
        else            mode_w = MODE_RUN;
    end

    assign mode_o = mode_w;

    p_uv_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (mode_o == MODE_OFF));
    p_en_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !uv_i) |=> (mode_o == MODE_OFF));
    p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trans && !uv_i) |=> !hiz_q);
    p_armed_in_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> hiz_q);
    p_legal_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11);
endmodule

// File: tb/dhz_mode_mgr_tb.sv
`timescale 1ns/1ps
module dhz_mode_mgr_tb;
    localparam int HOLD = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uv = 1'b1;
    logic       en = 1'b0;
    logic [1:0] pwm = 2'b10;
    logic       ovp = 1'b0;
    logic [1:0] mode;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R5";

    // Reference model state
    bit m_hiz, m_armed, m_latch, m_seen, m_uvp, m_en;
    int m_cnt;
    logic [1:0] m_prev;

    dhz_mode_mgr #(.HOLD_CYC(HOLD)) u_dut (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .en_i(en),
        .pwm_lvl_i(pwm), .ovp_i(ovp), .mode_o(mode)
    );

    always #5 clk = ~clk;

    // Behavioural reference updated on each rising edge.
    always @(posedge clk) begin
        bit win, tr, armed_old;
        if (!rst_n) begin
            m_hiz = 1; m_armed = 0; m_latch = 0; m_cnt = 0;
            m_prev = 2'b10; m_seen = 0; m_uvp = 1; m_en = 0;
        end else begin
            win = pwm[1];
            tr = m_seen && !win && (pwm != m_prev);
            armed_old = m_armed;
            if (uv) begin
                m_hiz = 1; m_armed = 0; m_latch = 0; m_cnt = 0;
            end else if (tr) begin
                m_hiz = 0; m_armed = 0; m_latch = 0; m_cnt = 0;
            end else begin
                if (armed_old && ovp) m_latch = 1;
                if (m_uvp) m_armed = 1;
                if (en && win && !m_hiz) begin
                    m_cnt++;
                    if (m_cnt == HOLD) begin m_hiz = 1; m_cnt = 0; end
                end else m_cnt = 0;
            end
            m_prev = pwm; m_seen = 1; m_uvp = uv; m_en = en;
        end
    end

    function automatic logic [1:0] exp_mode();
        if (m_uvp || !m_en) return 2'b00;
        if (m_latch) return 2'b10;
        if (m_hiz) return 2'b00;
        return 2'b01;
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: mode actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: compare against model, then drive next inputs.
    task automatic cyc(bit u, bit e, logic [1:0] p, bit o);
        @(negedge clk);
        check(tag, mode, exp_mode());
        uv = u; en = e; pwm = p; ovp = o;
    endtask

    task automatic rep(int n, bit u, bit e, logic [1:0] p, bit o);
        for (int i = 0; i < n; i++) cyc(u, e, p, o);
    endtask

    task automatic expect_now(string req, logic [1:0] exp);
        @(negedge clk);
        check(req, mode, exp);
        check(req, mode, exp_mode());
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        rep(3, 1, 0, 2'b10, 0);
        rst_n = 1'b1;
        expect_now("R5", 2'b00);
        // R1: undervoltage with enable and toggling PWM
        tag = "R1";
        for (int i = 0; i < 4; i++) cyc(1, 1, i[0] ? 2'b01 : 2'b00, 1);
        rep(2, 1, 1, 2'b01, 0);
        expect_now("R1", 2'b00);
        // R6: arm on supply good, latch on overvoltage
        tag = "R6";
        rep(3, 0, 1, 2'b10, 0);
        cyc(0, 1, 2'b11, 1);
        rep(2, 0, 1, 2'b10, 0);
        expect_now("R6", 2'b10);
        // R9: enable low keeps latch, returns when high
        tag = "R9";
        rep(3, 0, 0, 2'b10, 0);
        expect_now("R9", 2'b00);
        rep(2, 0, 1, 2'b10, 0);
        expect_now("R9", 2'b10);
        // R7: transition clears latch; later overvoltage ignored
        tag = "R7";
        rep(2, 0, 1, 2'b01, 1);
        expect_now("R7", 2'b01);
        // R10: normal switching
        tag = "R10";
        for (int i = 0; i < 8; i++) cyc(0, 1, i[0] ? 2'b00 : 2'b01, 0);
        expect_now("R10", 2'b01);
        // R3: short window stretch restarts count
        tag = "R3";
        rep(HOLD - 1, 0, 1, 2'b10, 0);
        rep(2, 0, 1, 2'b00, 0);
        rep(HOLD - 1, 0, 1, 2'b11, 0);
        cyc(0, 1, 2'b00, 0);
        expect_now("R3", 2'b01);
        rep(HOLD + 2, 0, 1, 2'b10, 0);
        expect_now("R3", 2'b00);
        // R7: overvoltage in a later high-impedance stretch has no effect
        tag = "R7";
        rep(4, 0, 1, 2'b10, 1);
        expect_now("R7", 2'b00);
        // R4: exit on transition, steady level stays normal
        tag = "R4";
        rep(5, 0, 1, 2'b00, 0);
        expect_now("R4", 2'b01);
        // R2: enable low regardless of PWM
        tag = "R2";
        for (int i = 0; i < 6; i++) cyc(0, 0, i[0] ? 2'b01 : 2'b10, 1);
        expect_now("R2", 2'b00);
        rep(HOLD + 3, 0, 0, 2'b10, 0);
        rep(2, 0, 1, 2'b10, 0);
        expect_now("R2", 2'b01);
        // R1: undervoltage re-forces off and re-arms on clear
        tag = "R1";
        rep(2, 1, 1, 2'b01, 0);
        expect_now("R1", 2'b00);
        rep(3, 0, 1, 2'b01, 1);
        expect_now("R1", 2'b10);
        // R4: reset with steady low stays high-impedance until a transition
        tag = "R4";
        rst_n = 1'b0;
        rep(2, 0, 1, 2'b00, 0);
        rst_n = 1'b1;
        rep(6, 0, 1, 2'b00, 0);
        expect_now("R4", 2'b00);
        rep(2, 0, 1, 2'b01, 0);
        expect_now("R4", 2'b01);
        // R8: code is always legal
        tag = "R8";
        rep(3, 0, 1, 2'b01, 0);
        @(negedge clk);
        n_chk++;
        if (mode == 2'b11) begin
            n_fail++;
            $display("FAIL R8: mode actual=%b expected=not 11", mode);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule